// File: doc/BRIEF.md
# Signed Booth Partial-Product Generator with Selected Final Row

This block forms the partial-product rows of a signed W×W multiplier using radix-4 (modified) Booth recoding, so a W-bit multiplier produces W/2 rows instead of W. It covers only the generation step of a multiplier. Reducing the rows to a sum row and a carry row, and adding those two rows, belong to downstream logic. The rows leave the block already aligned and sign-extended to the 2W-bit product width, so a reduction tree can take them as they are.

Every row except the last comes from a Booth encoder that drives a row generator. A row generator produces a negative multiple as the inverted magnitude and sets a separate carry-in bit for that row. The last row does not use a generator. A 3-to-5 decoder turns the top multiplier triplet into a one-hot select. That select drives a row of 5:1 selectors whose candidates are +2X, +X, 0, −X and −2X. A two's-complement unit works out −X and −2X from the multiplicand alone, in parallel with all of the encoding and decoding. The final row therefore carries a fully negated value and has no carry-in.

Top module: `booth_pp_gen`

## Requirements
- R1: The sum modulo 2^(2W) of all aligned rows and all carry-ins equals the signed product mcand_i × mplier_i. Both operands are two's complement. The carry-in neg_o[i] has weight 2^(2i).
- R2: Row i uses the triplet {mplier_i[2i+1], mplier_i[2i], mplier_i[2i−1]}, where mplier_i[−1] = 0. It maps to a digit: 000→0, 001→+1, 010→+1, 011→+2, 100→−2, 101→−1, 110→−1, 111→0.
- R3: Non-final row i is output in pp_o[i·2W +: 2W]. Its value is (digit·X − neg_o[i]), sign-extended and shifted left by 2i, taken modulo 2^(2W).
- R4: For a non-final row, neg_o[i] is 1 exactly when the row's digit is negative (triplets 100, 101, 110). In that case the row holds the bitwise inverse of the magnitude.
- R5: The last row equals digit·X, sign-extended and shifted left by W−2. Its carry-in neg_o[W/2−1] is always 0, for all eight triplet codes.
- R6: The last-row decoder drives exactly one of its five selects for each of the eight triplet codes.
- R7: The two's-complement candidate −X satisfies −X + X = 0 on W+2 bits for every multiplicand, including the most negative one.
- R8: Every row value, including its carry-in, lies within ±2^W. This holds even when both operands are −2^(W−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | W | Multiplicand X, two's complement |
| mplier_i | input | W | Multiplier Y, two's complement |
| pp_o | output | (W/2)·2W | Aligned, sign-extended partial-product rows; row i in slice [i·2W +: 2W] |
| neg_o | output | W/2 | Per-row carry-in for negative digits; bit i has weight 2^(2i); top bit always 0 |

## Verification
The bench runs the following input patterns:
- Zero operands show that negative digits on a zero multiplicand still cancel to zero through the carry-in.
- The most negative operand pairs test the ±2X range and the sign extension at the top of each row.
- Multipliers 0xAAAA and 0x5555 force a nonzero digit in every row, while long runs of ones collapse rows to 0.
- A sweep of all eight codes on the top triplet exercises each path of the selected final row.
- Seeded random operands check that the rows sum to the true product, and that each row matches the digit computed independently from the triplet.

// File: rtl/booth_pp_pkg.sv
package booth_pp_pkg;
  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } booth_op_t;

  localparam int SEL_N = 5;
  // one-hot select bit positions of the final-row decoder
  localparam int SEL_P2 = 0;
  localparam int SEL_P1 = 1;
  localparam int SEL_Z  = 2;
  localparam int SEL_N1 = 3;
  localparam int SEL_N2 = 4;
endpackage

// File: rtl/booth_enc.sv
module booth_enc
  import booth_pp_pkg::*;
(
  input  logic [2:0] trip_i,
  output booth_op_t  op_o
);
  always_comb begin
    op_o = '0;
    unique case (trip_i)
      3'b001, 3'b010: op_o.one = 1'b1;
      3'b011:         op_o.two = 1'b1;
      3'b100:         begin op_o.neg = 1'b1; op_o.two = 1'b1; end
      3'b101, 3'b110: begin op_o.neg = 1'b1; op_o.one = 1'b1; end
      default:        op_o = '0;
    endcase
  end

  // R2
  always_comb begin
    enc_exclusive_chk: assert (!(op_o.one && op_o.two));
  end
endmodule

// File: rtl/booth_row_gen.sv
module booth_row_gen
  import booth_pp_pkg::*;
#(
  parameter int W = 16,
  localparam int RW = W + 2
) (
  input  logic [W-1:0]  x_i,
  input  booth_op_t     op_i,
  output logic [RW-1:0] row_o,
  output logic          cin_o
);
  logic [RW-1:0] xe;
  logic [RW-1:0] mag;

  assign xe = {{2{x_i[W-1]}}, x_i};

  always_comb begin
    if (op_i.two)      mag = {xe[RW-2:0], 1'b0};
    else if (op_i.one) mag = xe;
    else               mag = '0;
  end

  // negative digit: invert here, add one downstream via cin
  assign row_o = op_i.neg ? ~mag : mag;
  assign cin_o = op_i.neg;

  // R4
  always_comb begin
    neg_has_mag_chk: assert (!cin_o || op_i.one || op_i.two);
  end
endmodule

// File: rtl/booth_dec5.sv
module booth_dec5
  import booth_pp_pkg::*;
(
  input  logic [2:0]       trip_i,
  output logic [SEL_N-1:0] sel_o
);
  always_comb begin
    sel_o = '0;
    unique case (trip_i)
      3'b001, 3'b010: sel_o[SEL_P1] = 1'b1;
      3'b011:         sel_o[SEL_P2] = 1'b1;
      3'b100:         sel_o[SEL_N2] = 1'b1;
      3'b101, 3'b110: sel_o[SEL_N1] = 1'b1;
      default:        sel_o[SEL_Z]  = 1'b1;
    endcase
  end

  // R6
  always_comb begin
    sel_onehot_chk: assert ($onehot(sel_o));
  end
endmodule

// File: rtl/booth_last_sel.sv
module booth_last_sel
  import booth_pp_pkg::*;
#(
  parameter int RW = 18
) (
  input  logic [SEL_N-1:0][RW-1:0] cand_i,
  input  logic [SEL_N-1:0]         sel_i,
  output logic [RW-1:0]            row_o
);
  always_comb begin
    row_o = '0;
    for (int k = 0; k < SEL_N; k++) begin
      row_o = row_o | (cand_i[k] & {RW{sel_i[k]}});
    end
  end
endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pp_pkg::*;
#(
  parameter int W = 16,
  localparam int ROWS = W / 2,
  localparam int RW   = W + 2,
  localparam int PW   = 2 * W
) (
  input  logic [W-1:0]         mcand_i,
  input  logic [W-1:0]         mplier_i,
  output logic [ROWS*PW-1:0]   pp_o,
  output logic [ROWS-1:0]      neg_o
);
  logic [W:0]              y_ext;
  logic [RW-1:0]           xe;
  logic [RW-1:0]           x_neg1;
  logic [RW-1:0]           x_neg2;
  logic [ROWS-1:0][RW-1:0] row_w;
  logic [SEL_N-1:0]        last_sel;
  logic [SEL_N-1:0][RW-1:0] cand;

  assign y_ext = {mplier_i, 1'b0};
  assign xe    = {{2{mcand_i[W-1]}}, mcand_i};

  // two's-complement unit: depends on multiplicand only, runs beside encoding
  assign x_neg1 = ~xe + RW'(1);
  assign x_neg2 = {x_neg1[RW-2:0], 1'b0};

  for (genvar i = 0; i < ROWS - 1; i++) begin : g_row
    booth_op_t op;
    booth_enc u_enc (
      .trip_i (y_ext[2*i+2 -: 3]),
      .op_o   (op)
    );
    booth_row_gen #(.W(W)) u_gen (
      .x_i   (mcand_i),
      .op_i  (op),
      .row_o (row_w[i]),
      .cin_o (neg_o[i])
    );
  end

  booth_dec5 u_dec (
    .trip_i (y_ext[W -: 3]),
    .sel_o  (last_sel)
  );

  always_comb begin
    cand         = '0;
    cand[SEL_P2] = {xe[RW-2:0], 1'b0};
    cand[SEL_P1] = xe;
    cand[SEL_N1] = x_neg1;
    cand[SEL_N2] = x_neg2;
  end

  booth_last_sel #(.RW(RW)) u_last (
    .cand_i (cand),
    .sel_i  (last_sel),
    .row_o  (row_w[ROWS-1])
  );
  assign neg_o[ROWS-1] = 1'b0;

  for (genvar i = 0; i < ROWS; i++) begin : g_align
    logic [PW-1:0] ext;
    assign ext = {{(PW-RW){row_w[i][RW-1]}}, row_w[i]};
    assign pp_o[i*PW +: PW] = ext << (2 * i);

    // R8
    logic signed [RW:0] val;
    assign val = $signed({row_w[i][RW-1], row_w[i]}) + $signed({{RW{1'b0}}, neg_o[i]});
    always_comb begin
      row_range_chk: assert ((val <= $signed((RW+1)'(1) <<< W)) &&
                             (val >= -$signed((RW+1)'(1) <<< W)));
    end
  end

  // R7
  always_comb begin
    twos_unit_chk: assert ((x_neg1 + xe) == '0);
  end

  // R5
  always_comb begin
    last_cin_chk: assert (!neg_o[ROWS-1]);
  end
endmodule

// File: tb/booth_pp_gen_tb.sv
module booth_pp_gen_tb_top;
  localparam int W    = 16;
  localparam int ROWS = W / 2;
  localparam int PW   = 2 * W;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic [W-1:0]       mcand, mplier;
  logic [ROWS*PW-1:0] pp;
  logic [ROWS-1:0]    neg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_pp_gen #(.W(W)) dut_i (
    .mcand_i  (mcand),
    .mplier_i (mplier),
    .pp_o     (pp),
    .neg_o    (neg)
  );

  function automatic int digit_of(input logic [2:0] t);
    case (t)
      3'b001, 3'b010: return 1;
      3'b011:         return 2;
      3'b100:         return -2;
      3'b101, 3'b110: return -1;
      default:        return 0;
    endcase
  endfunction

  function automatic logic [2:0] trip_of(input logic [W-1:0] y, input int i);
    logic [W:0] ye;
    ye = {y, 1'b0};
    return ye[2*i +: 3];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (x=%0d y=%0d)", req, act, exp,
               $signed(mcand), $signed(mplier));
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [PW-1:0] acc, exp_row, act_row, exp_prod;
    longint v;
    int d;
    bit exp_cin;
    @(posedge clk);
    mcand  = x;
    mplier = y;
    @(negedge clk);
    acc = '0;
    for (int i = 0; i < ROWS; i++) begin
      act_row = pp[i*PW +: PW];
      acc = acc + act_row + (PW'(neg[i]) << (2*i));
      d = digit_of(trip_of(y, i));
      if (i < ROWS - 1) begin
        exp_cin = (d < 0);
        // R4: carry-in flags negative digits
        check(neg[i] == exp_cin, "R4", longint'(neg[i]), longint'(exp_cin));
        v = longint'(d) * longint'($signed(x)) - longint'(exp_cin);
        exp_row = PW'(v <<< (2*i));
        // R2 R3: digit recoding, sign extension, alignment
        check(act_row == exp_row, "R3", longint'(act_row), longint'(exp_row));
      end else begin
        // R5: final row fully negated, no carry-in
        check(neg[i] == 1'b0, "R5", longint'(neg[i]), 0);
        v = longint'(d) * longint'($signed(x));
        exp_row = PW'(v <<< (2*i));
        check(act_row == exp_row, "R5", longint'(act_row), longint'(exp_row));
      end
    end
    exp_prod = PW'(longint'($signed(x)) * longint'($signed(y)));
    // R1: rows plus carries give the product
    check(acc == exp_prod, "R1", longint'(acc), longint'(exp_prod));
  endtask

  initial begin
    void'($urandom(32'h1BAD5EED));
    mcand = '0;
    mplier = '0;
    // zero operands: all rows must represent zero
    apply('0, '0);
    apply('0, 16'hFFFF);
    apply('0, 16'h4444);
    // R8: extreme operands
    apply(16'h8000, 16'h8000);
    apply(16'h7FFF, 16'h8000);
    apply(16'h8000, 16'h7FFF);
    apply(16'hFFFF, 16'hFFFF);
    apply(16'h7FFF, 16'h7FFF);
    // R2: every row nonzero digit, and long ones runs
    apply(16'd12345, 16'hAAAA);
    apply(-16'sd321, 16'h5555);
    apply(16'd999, 16'h7FFE);
    // R5 R6: sweep all eight top-triplet codes
    for (int t = 0; t < 8; t++) begin
      apply(16'd12345, 16'(t << 13));
      apply(16'h8000, 16'(t << 13) | 16'h0101);
      apply(-16'sd7, 16'(t << 13));
    end
    // R7: multiplicand corners through the negated candidates
    apply(16'h8000, 16'hC000);
    apply(16'h0001, 16'h8000);
    for (int n = 0; n < 2000; n++) begin
      apply(16'($urandom), 16'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule